// File: doc/BRIEF.md
# Flash Buffered-Program Command Interpreter

This block is the command state machine inside a parallel NOR flash device. It watches bus write cycles, each made of an address and a data word. It recognises a multi-step buffered-program sequence: a setup opcode, then a word count, then the buffer data words, then a confirm opcode. While these arrive, it collects the data words in an internal buffer. After a valid confirm, it writes the buffered words to the array port, one per clock, starting at the address of the first data word. A parameterised busy period follows the last word.

The block keeps a status byte. Its ready flag is low while the operation runs. Two sticky error flags record malformed sequences. A mode output tells the bus read logic whether reads should return this status byte or array contents. The block also accepts commands that clear the error flags, select status reads and return to array reads.

Top module: `flash_bufprog_ctl`

## Requirements
- R1: After reset, `status` is 8'h80 (bit 7 ready = 1, all other bits 0), `rd_status_mode` is 0 and `arr_we` is 0.
- R2: When ready and idle, a write whose low data byte is E8h (setup) or 70h (status read) sets `rd_status_mode` to 1, and FFh clears it. `rd_status_mode` stays 1 for as long as bit 7 is 0.
- R3: The write that follows setup is always taken as the word count N, including when it carries 70h. The block then takes exactly N+1 data writes before the confirm slot. N ranges from 0 (one word) to BUF_WORDS-1.
- R4: After a confirm, `arr_we` is high for N+1 consecutive cycles. In cycle i it presents `arr_addr` = start + i and the i-th data word on `arr_data`. Start is the address of the first data write.
- R5: A data write whose block field (`wr_addr` bits [AW-1 -: BLK_W]) differs from the block latched with the setup write aborts the sequence. The abort sets status bit 5 (sequence error), leaves bit 4 unchanged, returns to idle and writes nothing to the array.
- R6: Any write in the confirm slot whose low byte is not D0h aborts the sequence. The abort sets both status bit 5 and status bit 4 (program error) and writes nothing to the array.
- R7: A word count of BUF_WORDS or more (full data word compared) aborts the sequence with status bit 5 set. The block returns to idle, so the next write is decoded as a command.
- R8: Status bit 7 falls in the cycle after the confirm write. It stays 0 for exactly N+1+BUSY_CYC cycles.
- R9: While bit 7 is 0, writes other than 70h are ignored: FFh, 50h and E8h change neither the mode nor the error bits, and do not start a new sequence. The array write stream continues unaffected.
- R10: When idle, a write of 50h clears status bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data; commands are decoded from bits [7:0] |
| rd_status_mode | output | 1 | 1: reads return the status byte; 0: reads return the array |
| status | output | 8 | Status byte: bit 7 ready, bit 5 sequence error, bit 4 program error |
| arr_we | output | 1 | Array word write strobe during programming |
| arr_addr | output | AW | Array write address |
| arr_data | output | DW | Array write data from the word buffer |

## Verification
Two things can happen in the same cycle while the block is busy. The buffer drains one word to the array, and a new bus write arrives that must be filtered. The bench provokes this by issuing FFh, 50h, E8h and 70h right after a confirm. Error bits were left set beforehand, so a wrongly accepted clear would show. A scoreboard queue holds the expected address and data of every array write. A monitor pops and compares an entry on each `arr_we` cycle, so any disturbance of the drain stream shows up as a mismatch. After the busy period ends, the bench checks the mode and the status byte. It then sends one FFh to show that the ignored setup did not open a new sequence.

// File: rtl/flashbp_pkg.sv
package flashbp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_FILL,
    ST_CONFIRM,
    ST_DRAIN,
    ST_SETTLE
  } bp_state_t;

  localparam logic [7:0] OP_BUF_SETUP = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_CLEAR     = 8'h50;
  localparam logic [7:0] OP_ARRAY     = 8'hFF;

endpackage

// File: rtl/bp_busy_timer.sv
module bp_busy_timer #(
  parameter int BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last
);
  localparam int CNTW = $clog2(BUSY_CYC + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CNTW'(BUSY_CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNTW'(1));
endmodule

// File: rtl/bp_word_buf.sv
module bp_word_buf #(
  parameter int WORDS = 256,
  parameter int DW    = 16,
  localparam int CW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/bp_seq_ctrl.sv
module bp_seq_ctrl
  import flashbp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int BLK_W = 4,
  parameter int WORDS = 256,
  localparam int CW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tmr_last,
  output logic          buf_we,
  output logic [CW-1:0] buf_idx,
  output logic          tmr_start,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    status,
  output logic          rd_status_mode
);
  bp_state_t        st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [CW-1:0]    cnt_q, cnt_d, idx_q, idx_d;
  logic [AW-1:0]    base_q, base_d;
  logic             seq_q, seq_d, prg_q, prg_d, mode_q, mode_d;
  logic [7:0]       op;
  logic             in_blk, ready;

  assign op     = wr_data[7:0];
  assign in_blk = (wr_addr[AW-1 -: BLK_W] == blk_q);
  assign ready  = (st_q != ST_DRAIN) && (st_q != ST_SETTLE);

  always_comb begin
    st_d = st_q;  blk_d = blk_q;  cnt_d = cnt_q;  idx_d = idx_q;
    base_d = base_q;  seq_d = seq_q;  prg_d = prg_q;  mode_d = mode_q;
    buf_we = 1'b0;
    tmr_start = 1'b0;
    case (st_q)
      ST_IDLE: if (wr_en) begin
        case (op)
          OP_BUF_SETUP: begin
            st_d   = ST_COUNT;
            blk_d  = wr_addr[AW-1 -: BLK_W];
            mode_d = 1'b1;
          end
          OP_STATUS: mode_d = 1'b1;
          OP_CLEAR:  begin seq_d = 1'b0; prg_d = 1'b0; end
          OP_ARRAY:  mode_d = 1'b0;
          default: ;
        endcase
      end
      ST_COUNT: if (wr_en) begin
        if (wr_data >= DW'(WORDS)) begin
          seq_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = wr_data[CW-1:0];
          idx_d = '0;
          st_d  = ST_FILL;
        end
      end
      ST_FILL: if (wr_en) begin
        if (!in_blk) begin
          seq_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          buf_we = 1'b1;
          if (idx_q == '0) base_d = wr_addr;
          if (idx_q == cnt_q) st_d = ST_CONFIRM;
          else                idx_d = idx_q + 1'b1;
        end
      end
      ST_CONFIRM: if (wr_en) begin
        if (op == OP_CONFIRM) begin
          st_d  = ST_DRAIN;
          idx_d = '0;
        end else begin
          seq_d = 1'b1;
          prg_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (wr_en && op == OP_STATUS) mode_d = 1'b1;
        if (idx_q == cnt_q) begin
          st_d      = ST_SETTLE;
          tmr_start = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (wr_en && op == OP_STATUS) mode_d = 1'b1;
        if (tmr_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      blk_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
      seq_q  <= 1'b0;
      prg_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      seq_q  <= seq_d;
      prg_q  <= prg_d;
      mode_q <= mode_d;
    end
  end

  assign buf_idx        = idx_q;
  assign arr_we         = (st_q == ST_DRAIN);
  assign arr_addr       = base_q + AW'(idx_q);
  assign status         = {ready, 1'b0, seq_q, prg_q, 4'b0000};
  assign rd_status_mode = mode_q;
endmodule

// File: rtl/flash_bufprog_ctl.sv
module flash_bufprog_ctl #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BLK_W     = 4,
  parameter int BUF_WORDS = 256,
  parameter int BUSY_CYC  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rd_status_mode,
  output logic [7:0]    status,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);
  localparam int CW = $clog2(BUF_WORDS);

  logic [1:0]    rsync_q;
  logic          rst_i_n;
  logic          buf_we, tmr_start, tmr_last;
  logic [CW-1:0] buf_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bp_seq_ctrl #(
    .AW(AW), .DW(DW), .BLK_W(BLK_W), .WORDS(BUF_WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_last(tmr_last),
    .buf_we(buf_we), .buf_idx(buf_idx), .tmr_start(tmr_start),
    .arr_we(arr_we), .arr_addr(arr_addr),
    .status(status), .rd_status_mode(rd_status_mode)
  );

  bp_word_buf #(
    .WORDS(BUF_WORDS), .DW(DW)
  ) u_buf (
    .clk(clk), .we(buf_we), .idx(buf_idx), .wdata(wr_data), .rdata(arr_data)
  );

  bp_busy_timer #(
    .BUSY_CYC(BUSY_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .start(tmr_start), .last(tmr_last)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_status_mode,
  input logic [7:0]    status,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr
);
  assert_drain_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !status[7]);

  assert_drain_sequential_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> (!arr_we || (arr_addr - $past(arr_addr)) == AW'(1)));

  assert_prgerr_with_seqerr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> status[5]);

  assert_busy_errs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |=> $stable(status[5:4]));

  assert_busy_reads_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> rd_status_mode);
endmodule

bind flash_bufprog_ctl bp_checker #(.AW(AW)) u_bp_checker (
  .clk(clk), .rst_n(rst_n), .rd_status_mode(rd_status_mode),
  .status(status), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_flash_bufprog_ctl.sv
module tb_flash_bufprog_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 20;

  logic        clk, rst_n, wr_en;
  logic [15:0] wr_addr, wr_data;
  logic        rd_status_mode, arr_we;
  logic [7:0]  status;
  logic [15:0] arr_addr, arr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_q[$];

  flash_bufprog_ctl #(.BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_status_mode(rd_status_mode), .status(status),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: each array write is compared with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected array write actual=%h expected=none", {arr_addr, arr_data});
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if ({arr_addr, arr_data} !== e) begin
          fails++;
          $display("FAIL R4 array write actual=%h expected=%h", {arr_addr, arr_data}, e);
        end
      end
    end
  end

  task automatic issue(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: full legal sequence, expected array writes pushed to the scoreboard
  task automatic load_seq(input logic [3:0] blk, input logic [15:0] start,
                          input int n, input logic [15:0] seed);
    issue({blk, 12'h000}, 16'h00E8);
    issue({blk, 12'h000}, 16'(n));
    for (int i = 0; i <= n; i++) begin
      logic [15:0] a, d;
      a = start + 16'(i);
      d = seed ^ (16'(i) * 16'h0123);
      exp_q.push_back({a, d});
      issue(a, d);
    end
    issue({blk, 12'h000}, 16'h00D0);
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (!status[7]) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 mode", 32'(rd_status_mode), 32'h0);
    chk("R1 arr_we", 32'(arr_we), 32'h0);

    // R2 mode commands when idle
    issue(16'h1000, 16'h0070);
    chk("R2 70h sets mode", 32'(rd_status_mode), 32'h1);
    issue(16'h1000, 16'h00FF);
    chk("R2 FFh clears mode", 32'(rd_status_mode), 32'h0);

    // R4/R8 basic program, N=3
    load_seq(4'h3, 16'h3010, 3, 16'hA5C3);
    chk("R2 setup selects status", 32'(rd_status_mode), 32'h1);
    wait_ready(cyc);
    chk("R8 busy length N=3", 32'(cyc), 32'(4 + BUSY));
    chk("R4 all words written", 32'(exp_q.size()), 32'h0);
    chk("R8 ready status", 32'(status), 32'h80);

    // R3 single word, unaligned start
    load_seq(4'h9, 16'h9ABD, 0, 16'h1234);
    wait_ready(cyc);
    chk("R3 N=0 busy length", 32'(cyc), 32'(1 + BUSY));
    chk("R3 N=0 one word", 32'(exp_q.size()), 32'h0);

    // R3 70h in count slot is a count of 112
    load_seq(4'h5, 16'h5200, 16'h70, 16'h0F0F);
    wait_ready(cyc);
    chk("R3 70h as count busy length", 32'(cyc), 32'(16'h71 + BUSY));
    chk("R3 70h as count words", 32'(exp_q.size()), 32'h0);

    // R5 out-of-block data aborts
    issue(16'h2000, 16'h00E8);
    issue(16'h2000, 16'h0002);
    issue(16'h2004, 16'h1111);
    issue(16'h5004, 16'h2222);
    chk("R5 abort status", 32'(status), 32'hA0);
    repeat (4) @(negedge clk);
    chk("R5 no array write", 32'(exp_q.size()), 32'h0);

    // R10 clear
    issue(16'h0000, 16'h0050);
    chk("R10 clear errors", 32'(status), 32'h80);

    // R6 bad confirm
    issue(16'h4000, 16'h00E8);
    issue(16'h4000, 16'h0001);
    issue(16'h4010, 16'h3333);
    issue(16'h4011, 16'h4444);
    issue(16'h4000, 16'h00AA);
    chk("R6 bad confirm status", 32'(status), 32'hB0);
    repeat (4) @(negedge clk);
    issue(16'h0000, 16'h0050);
    chk("R10 clear both bits", 32'(status), 32'h80);

    // R7 count too large
    issue(16'h6000, 16'h00E8);
    issue(16'h6000, 16'h0100);
    chk("R7 overflow status", 32'(status), 32'hA0);
    issue(16'h6000, 16'h00FF);
    chk("R7 back to command decode", 32'(rd_status_mode), 32'h0);

    // R9 commands during busy while drain runs; bit 5 left set
    load_seq(4'hC, 16'hC100, 15, 16'h5AA5);
    issue(16'hC000, 16'h00FF);
    issue(16'hC000, 16'h0050);
    issue(16'hC000, 16'h00E8);
    issue(16'hC000, 16'h0070);
    chk("R9 mode held in busy", 32'(rd_status_mode), 32'h1);
    chk("R9 errors held in busy", 32'(status), 32'h20);
    wait_ready(cyc);
    chk("R9 status after busy", 32'(status), 32'hA0);
    chk("R9 stream intact", 32'(exp_q.size()), 32'h0);
    issue(16'hC000, 16'h00FF);
    chk("R9 setup was ignored", 32'(rd_status_mode), 32'h0);
    issue(16'h0000, 16'h0050);
    chk("R10 clear after busy", 32'(status), 32'h80);

    // R3 maximum count, full buffer at a block boundary
    load_seq(4'h7, 16'h7000, 255, 16'hBEEF);
    wait_ready(cyc);
    chk("R3 N=FFh busy length", 32'(cyc), 32'(256 + BUSY));
    chk("R3 N=FFh all words", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule